// File: doc/BRIEF.md
# Bandwidth-Aware Spatial Prefetch Selector

This block turns the first access to a fresh memory page into a burst of prefetch requests for other lines of that page. With the trigger it receives the result of a signature-table lookup for the triggering instruction. That result holds a hit flag, two anchored footprints and two 2-bit quality counters. One footprint leans towards coverage and the other towards accuracy. The block also receives the current memory-bandwidth utilization as a quartile bucket. From the bucket and from the saturation of the two counters it picks one footprint, or none. A counter is saturated when it holds 3.

An anchored footprint stores the trigger line at bit 0. The block rotates the chosen footprint left by the trigger's line offset so that each bit lines up with its real line in the page, then clears the trigger line's own bit. The remaining set bits are sent as full line addresses (page number and line offset) through a valid/ready port. They go out one per accepted handshake, lowest offset first. While a burst is in flight the block reports busy. A trigger that arrives during that time is dropped and never merged. Table training and bandwidth measurement take place elsewhere.

Bandwidth bucket encoding: 0 means below 25%, 1 means 25% to below 50%, 2 means 50% to below 75%, 3 means 75% or more.

Top module: `spatial_pf_select`

## Requirements
- R1: After reset, pfValid and busy are low and no request is offered until a trigger is accepted.
- R2: With bwBucket = 3 and accQual = 3, an accepted trigger produces no prefetch.
- R3: With bwBucket = 3 and accQual below 3, the accuracy footprint (accPattern) is used.
- R4: With bwBucket = 2 and covQual = 3, the accuracy footprint is used.
- R5: With bwBucket = 2 and covQual below 3, the coverage footprint (covPattern) is used.
- R6: With bwBucket = 0 or 1, the coverage footprint is used, whatever the quality counters hold.
- R7: Bit k of the chosen footprint requests line offset (k + trigOffset) mod 64, and pfLine = {trigPage, offset}, with the offset in the low 6 bits.
- R8: The trigger's own line is never requested.
- R9: Requests leave in ascending offset order, one per cycle while pfReady is high. While pfValid is high and pfReady is low, pfLine holds steady.
- R10: A trigger presented while busy is high is dropped. Only the lines of the burst in progress are emitted, and the block then returns to idle.
- R11: When sigHit is low, a trigger produces no prefetch.
- R12: If the chosen footprint has no bit set other than the trigger line, no prefetch is issued and the block stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| trigValid | input | 1 | First access to a page (trigger) |
| trigPage | input | 20 | Page number of the trigger |
| trigOffset | input | 6 | Line offset of the trigger within the page |
| sigHit | input | 1 | Signature table lookup hit |
| covPattern | input | 64 | Anchored coverage-biased footprint |
| accPattern | input | 64 | Anchored accuracy-biased footprint |
| covQual | input | 2 | Coverage-footprint quality counter |
| accQual | input | 2 | Accuracy-footprint quality counter |
| bwBucket | input | 2 | Bandwidth utilization quartile |
| busy | output | 1 | Burst in progress; new triggers are dropped |
| pfValid | output | 1 | Prefetch request valid |
| pfLine | output | 26 | Prefetch line address {page, offset} |
| pfReady | input | 1 | Prefetch request accepted |

## Verification
A trigger sampled at a rising edge drives pfValid high, with the lowest pending line on pfLine, from that edge onward. Each handshake edge moves to the next line, and the edge after the last handshake drops both pfValid and busy. For a trigger that must not prefetch, pfValid stays low in the cycle after the trigger. The bench drives inputs on falling edges and reads outputs there too. It compares each offered line against the next lowest bit of a footprint it computed itself. Exactly one cycle after the final handshake it checks that the block is idle again.

// File: rtl/spf_pkg.sv
package spf_pkg;
  typedef enum logic [1:0] {SEL_NONE, SEL_COV, SEL_ACC} selT;

  typedef struct packed {
    logic load;
    logic consume;
    logic useAcc;
  } strobeT;
endpackage

// File: rtl/spf_ctrl.sv
module spf_ctrl
  import spf_pkg::*;
#(
  parameter int QW = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          trigValid,
  input  logic          sigHit,
  input  logic [1:0]    bwBucket,
  input  logic [QW-1:0] covQual,
  input  logic [QW-1:0] accQual,
  input  logic          candAny,
  input  logic          lastBit,
  input  logic          pfReady,
  output strobeT        strobe,
  output logic          busy
);
  localparam logic [QW-1:0] QMAX = '1;

  selT  sel;
  logic busyQ;

  // Selection by bandwidth headroom and counter saturation
  always_comb begin
    unique case (bwBucket)
      2'd3:    sel = (accQual == QMAX) ? SEL_NONE : SEL_ACC;
      2'd2:    sel = (covQual == QMAX) ? SEL_ACC : SEL_COV;
      default: sel = SEL_COV;
    endcase
  end

  always_comb begin
    strobe.useAcc  = (sel == SEL_ACC);
    strobe.load    = trigValid && !busyQ && sigHit && (sel != SEL_NONE) && candAny;
    strobe.consume = busyQ && pfReady;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                              busyQ <= 1'b0;
    else if (strobe.load)                   busyQ <= 1'b1;
    else if (strobe.consume && lastBit)     busyQ <= 1'b0;
  end

  assign busy = busyQ;
endmodule

// File: rtl/spf_dp.sv
module spf_dp
  import spf_pkg::*;
#(
  parameter int LINES  = 64,
  parameter int PAGE_W = 20,
  localparam int OFF_W = $clog2(LINES)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  strobeT                  strobe,
  input  logic [PAGE_W-1:0]       trigPage,
  input  logic [OFF_W-1:0]        trigOffset,
  input  logic [LINES-1:0]        covPattern,
  input  logic [LINES-1:0]        accPattern,
  output logic                    candAny,
  output logic                    lastBit,
  output logic [PAGE_W+OFF_W-1:0] pfLine
);
  logic [LINES-1:0]  anchored;
  logic [LINES-1:0]  rotated;
  logic [LINES-1:0]  cand;
  logic [LINES-1:0]  patQ;
  logic [PAGE_W-1:0] pageQ;
  logic [OFF_W-1:0]  lowIdx;

  assign anchored = strobe.useAcc ? accPattern : covPattern;

  // Un-anchor: rotate left by the trigger offset, then drop the trigger line
  for (genvar g = 0; g < LINES; g++) begin : gRot
    logic [OFF_W-1:0] srcIdx;
    assign srcIdx  = OFF_W'(g) - trigOffset;
    assign rotated[g] = anchored[srcIdx];
    assign cand[g]    = rotated[g] && (trigOffset != OFF_W'(g));
  end

  assign candAny = |cand;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      patQ  <= '0;
      pageQ <= '0;
    end else if (strobe.load) begin
      patQ  <= cand;
      pageQ <= trigPage;
    end else if (strobe.consume) begin
      patQ  <= patQ & (patQ - LINES'(1));
    end
  end

  // Lowest pending line
  always_comb begin
    lowIdx = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (patQ[i]) lowIdx = OFF_W'(i);
    end
  end

  assign lastBit = ((patQ & (patQ - LINES'(1))) == '0);
  assign pfLine  = {pageQ, lowIdx};
endmodule

// File: rtl/spatial_pf_select.sv
module spatial_pf_select
  import spf_pkg::*;
#(
  parameter int LINES  = 64,
  parameter int PAGE_W = 20,
  parameter int QW     = 2,
  localparam int OFF_W = $clog2(LINES)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    trigValid,
  input  logic [PAGE_W-1:0]       trigPage,
  input  logic [OFF_W-1:0]        trigOffset,
  input  logic                    sigHit,
  input  logic [LINES-1:0]        covPattern,
  input  logic [LINES-1:0]        accPattern,
  input  logic [QW-1:0]           covQual,
  input  logic [QW-1:0]           accQual,
  input  logic [1:0]              bwBucket,
  output logic                    busy,
  output logic                    pfValid,
  output logic [PAGE_W+OFF_W-1:0] pfLine,
  input  logic                    pfReady
);
  strobeT strobe;
  logic   candAny;
  logic   lastBit;
  logic   busyInt;

  spf_ctrl #(.QW(QW)) u_ctrl (
    .clk(clk), .rstN(rstN), .trigValid(trigValid), .sigHit(sigHit),
    .bwBucket(bwBucket), .covQual(covQual), .accQual(accQual),
    .candAny(candAny), .lastBit(lastBit), .pfReady(pfReady),
    .strobe(strobe), .busy(busyInt)
  );

  spf_dp #(.LINES(LINES), .PAGE_W(PAGE_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .trigPage(trigPage),
    .trigOffset(trigOffset), .covPattern(covPattern), .accPattern(accPattern),
    .candAny(candAny), .lastBit(lastBit), .pfLine(pfLine)
  );

  assign busy    = busyInt;
  assign pfValid = busyInt;
endmodule

// File: rtl/spatial_pf_select_chk.sv
module spatial_pf_select_chk #(
  parameter int LINES  = 64,
  parameter int PAGE_W = 20,
  parameter int QW     = 2,
  localparam int OFF_W = $clog2(LINES)
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    trigValid,
  input logic [OFF_W-1:0]        trigOffset,
  input logic                    sigHit,
  input logic [QW-1:0]           accQual,
  input logic [1:0]              bwBucket,
  input logic                    busy,
  input logic                    pfValid,
  input logic [PAGE_W+OFF_W-1:0] pfLine,
  input logic                    pfReady
);
  logic [OFF_W-1:0] seenOff;
  always_ff @(posedge clk) begin
    if (!rstN)                    seenOff <= '0;
    else if (trigValid && !busy)  seenOff <= trigOffset;
  end

  // R1
  p_reset_idle_r1: assert property (@(posedge clk) !rstN |=> !pfValid && !busy);

  // R2
  p_no_pf_high_bw_r2: assert property (@(posedge clk) disable iff (!rstN)
    (trigValid && !busy && bwBucket == 2'd3 && accQual == '1) |=> !pfValid);

  // R8
  p_skip_trigger_r8: assert property (@(posedge clk) disable iff (!rstN)
    pfValid |-> (pfLine[OFF_W-1:0] != seenOff));

  // R9 hold while stalled
  p_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (pfValid && !pfReady) |=> (pfValid && $stable(pfLine)));

  // R9 ascending order
  p_ascend_r9: assert property (@(posedge clk) disable iff (!rstN)
    (pfValid && pfReady) |=> (!pfValid || (pfLine[OFF_W-1:0] > $past(pfLine[OFF_W-1:0]))));

  // R10 page unchanged by a dropped trigger
  p_drop_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && trigValid) |=> (!pfValid ||
      (pfLine[PAGE_W+OFF_W-1:OFF_W] == $past(pfLine[PAGE_W+OFF_W-1:OFF_W]))));

  // R11
  p_miss_r11: assert property (@(posedge clk) disable iff (!rstN)
    (trigValid && !busy && !sigHit) |=> !pfValid);
endmodule

bind spatial_pf_select spatial_pf_select_chk #(.LINES(LINES), .PAGE_W(PAGE_W), .QW(QW)) u_chk (
  .clk(clk), .rstN(rstN), .trigValid(trigValid), .trigOffset(trigOffset),
  .sigHit(sigHit), .accQual(accQual), .bwBucket(bwBucket), .busy(busy),
  .pfValid(pfValid), .pfLine(pfLine), .pfReady(pfReady)
);

// File: tb/spatial_pf_select_bench.sv
`timescale 1ns/1ps
module spatial_pf_select_bench;
  localparam int LINES  = 64;
  localparam int PAGE_W = 20;
  localparam int OFF_W  = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic trigValid = 1'b0;
  logic [PAGE_W-1:0] trigPage = '0;
  logic [OFF_W-1:0]  trigOffset = '0;
  logic sigHit = 1'b0;
  logic [LINES-1:0] covPattern = '0;
  logic [LINES-1:0] accPattern = '0;
  logic [1:0] covQual = '0;
  logic [1:0] accQual = '0;
  logic [1:0] bwBucket = '0;
  logic busy;
  logic pfValid;
  logic [PAGE_W+OFF_W-1:0] pfLine;
  logic pfReady = 1'b0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int seed = 0;

  always #2.5 clk = ~clk;

  spatial_pf_select u_spatial_pf_select (
    .clk(clk), .rstN(rstN), .trigValid(trigValid), .trigPage(trigPage),
    .trigOffset(trigOffset), .sigHit(sigHit), .covPattern(covPattern),
    .accPattern(accPattern), .covQual(covQual), .accQual(accQual),
    .bwBucket(bwBucket), .busy(busy), .pfValid(pfValid), .pfLine(pfLine),
    .pfReady(pfReady)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected un-anchored pattern from the requirement rules
  function automatic logic [LINES-1:0] expPat(input logic hit, input logic [1:0] bw,
      input logic [1:0] cq, input logic [1:0] aq, input logic [LINES-1:0] cov,
      input logic [LINES-1:0] acc, input logic [OFF_W-1:0] off);
    logic [LINES-1:0] a;
    logic [LINES-1:0] r;
    if (!hit) return '0;
    if (bw == 2'd3) begin
      if (aq == 2'd3) return '0;
      a = acc;
    end else if (bw == 2'd2) begin
      a = (cq == 2'd3) ? acc : cov;
    end else begin
      a = cov;
    end
    for (int i = 0; i < LINES; i++) r[(i + off) % LINES] = a[i];
    r[off] = 1'b0;
    return r;
  endfunction

  function automatic int lowestBit(input logic [LINES-1:0] p);
    for (int i = 0; i < LINES; i++) if (p[i]) return i;
    return -1;
  endfunction

  // Drain a burst; optionally inject a dropped trigger at the given step
  task automatic drain(input logic [PAGE_W-1:0] page, input logic [LINES-1:0] exp,
                       input string req, input bit randReady, input int dropAt);
    logic [LINES-1:0] rem = exp;
    int step = 0;
    while (rem != '0) begin
      int lb = lowestBit(rem);
      check(pfValid === 1'b1 && pfLine === {page, OFF_W'(lb)},
            {req, " R7 R9 line"}, 64'(pfLine), 64'({page, OFF_W'(lb)}));
      pfReady = randReady ? (($urandom(seed) % 3) != 0) : 1'b1;
      if (step == dropAt) begin
        pfReady = 1'b0;
        trigValid = 1'b1;
        trigPage = page ^ 20'h5A5A5;
        trigOffset = 6'd0;
        sigHit = 1'b1;
        bwBucket = 2'd0;
        covPattern = '1;
      end
      @(posedge clk);
      @(negedge clk);
      if (step == dropAt) begin
        check(busy === 1'b1, "R10 busy while dropping", 64'(busy), 64'd1);
        trigValid = 1'b0;
      end
      if (pfReady) rem[lb] = 1'b0;
      step++;
    end
    pfReady = 1'b0;
    check(pfValid === 1'b0 && busy === 1'b0, {req, " R9 idle after burst"},
          64'({busy, pfValid}), 64'd0);
  endtask

  task automatic runTrig(input logic [PAGE_W-1:0] page, input logic [OFF_W-1:0] off,
      input logic hit, input logic [1:0] bw, input logic [1:0] cq, input logic [1:0] aq,
      input logic [LINES-1:0] cov, input logic [LINES-1:0] acc, input string req,
      input bit randReady, input int dropAt);
    logic [LINES-1:0] exp = expPat(hit, bw, cq, aq, cov, acc, off);
    trigValid = 1'b1; trigPage = page; trigOffset = off; sigHit = hit;
    bwBucket = bw; covQual = cq; accQual = aq; covPattern = cov; accPattern = acc;
    @(posedge clk);
    @(negedge clk);
    trigValid = 1'b0;
    if (exp == '0)
      check(pfValid === 1'b0 && busy === 1'b0, {req, " no prefetch"}, 64'(pfValid), 64'd0);
    else
      drain(page, exp, req, randReady, dropAt);
  endtask

  logic [LINES-1:0] cv;
  logic [LINES-1:0] ac;

  initial begin
    seed = 1234;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(pfValid === 1'b0 && busy === 1'b0, "R1 reset", 64'({busy, pfValid}), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(pfValid === 1'b0 && busy === 1'b0, "R1 idle after reset", 64'({busy, pfValid}), 64'd0);

    cv = 64'h0000_0000_0000_00F3;
    ac = 64'h0000_0000_0000_0041;
    // R2: high bw, acc counter saturated
    runTrig(20'h00011, 6'd5, 1'b1, 2'd3, 2'd0, 2'd3, cv, ac, "R2", 1'b0, -1);
    // R3: high bw, acc counter not saturated
    runTrig(20'h00012, 6'd5, 1'b1, 2'd3, 2'd3, 2'd2, cv, ac, "R3", 1'b0, -1);
    // R4: mid bw, cov counter saturated
    runTrig(20'h00013, 6'd9, 1'b1, 2'd2, 2'd3, 2'd0, cv, ac, "R4", 1'b0, -1);
    // R5: mid bw, cov counter not saturated
    runTrig(20'h00014, 6'd9, 1'b1, 2'd2, 2'd1, 2'd3, cv, ac, "R5", 1'b0, -1);
    // R6: low bw buckets ignore counters
    runTrig(20'h00015, 6'd0, 1'b1, 2'd0, 2'd3, 2'd3, cv, ac, "R6", 1'b0, -1);
    runTrig(20'h00016, 6'd1, 1'b1, 2'd1, 2'd3, 2'd3, cv, ac, "R6", 1'b1, -1);
    // R7: wrap-around rotation near the page end
    runTrig(20'hABCDE, 6'd62, 1'b1, 2'd0, 2'd0, 2'd0, 64'h8000_0000_0000_000F, ac, "R7 wrap", 1'b1, -1);
    // R8: all-ones footprint, trigger in the middle
    runTrig(20'h00020, 6'd33, 1'b1, 2'd0, 2'd0, 2'd0, '1, ac, "R8", 1'b1, -1);
    // R11: signature miss
    runTrig(20'h00021, 6'd4, 1'b0, 2'd0, 2'd0, 2'd0, '1, '1, "R11", 1'b0, -1);
    // R12: only the trigger bit set
    runTrig(20'h00022, 6'd17, 1'b1, 2'd0, 2'd0, 2'd0, 64'h1, '1, "R12", 1'b0, -1);
    // R10: trigger during a stalled burst is dropped
    runTrig(20'h00030, 6'd2, 1'b1, 2'd0, 2'd0, 2'd0, 64'h0000_0000_0000_1234, ac, "R10", 1'b0, 1);

    // Random mix
    for (int n = 0; n < 300; n++) begin
      logic [LINES-1:0] c;
      logic [LINES-1:0] a;
      c = {$urandom(seed), $urandom(seed)} & {$urandom(seed), $urandom(seed)};
      a = c & {$urandom(seed), $urandom(seed)};
      runTrig(20'($urandom(seed)), 6'($urandom(seed)), ($urandom(seed) % 8) != 0,
              2'($urandom(seed)), 2'($urandom(seed)), 2'($urandom(seed)), c, a,
              "R2 R3 R4 R5 R6 random", 1'b1, (n % 7 == 0) ? 0 : -1);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule